// File: doc/BRIEF.md
# Pulse-and-Verify Byte Programming Sequencer

This block sits on the host side of a parallel NOR-style flash and writes one byte with a closed loop. It does not rely on a single write. Each attempt stages the device with a set-up command and then writes the target address and data byte. That second write opens a fixed-length program pulse. After the pulse time the block closes the pulse with a verify command, waits out a recovery time, and reads the byte back. If the read-back value equals the intended byte, the loop ends successfully. If not, another attempt follows, up to a fixed pulse budget. In either case the block finishes with a command that returns the device to plain read mode.

A requester pulses `start_i` with an address and a byte. It then waits for a one-cycle `done_o` (success) or `fail_o` (budget exhausted). The number of pulses used is reported on `tries_o` alongside the pulse. All timing is counted in clock cycles: the pulse length, the recovery delay and the strobe widths. The data bus is split into an output, an output enable and an input, so that the pad ring can form the bidirectional pins.

Top module: `byte_prog_seq`

## Requirements
- R1: While reset is held, and in the first idle cycle after it, all three flash strobes are high, `flash_dq_oe` is 0, and `busy_o`, `done_o` and `fail_o` are 0.
- R2: Every attempt starts with a flash write of 40h. The next write carries the requested address and data byte.
- R3: After the address/data write, at least `PULSE_CYC` cycles pass from its write-enable rising edge to the falling edge of the next write. That next write is C0h.
- R4: The verify read follows the C0h write. Output enable falls no earlier than `RECOV_CYC` cycles after the C0h write-enable rising edge, with the requested address on the bus.
- R5: When the read-back byte equals the requested byte, the block ends the loop. It then pulses `done_o` with `tries_o` equal to the number of program pulses issued.
- R6: When the read-back still differs after the `MAX_PULSES`-th pulse, the block issues no further pulse. It pulses `fail_o` with `tries_o` equal to `MAX_PULSES`.
- R7: The last flash write before `done_o` or `fail_o` is 00h. It follows the final verify read.
- R8: In every flash write, the address and driven data stay unchanged from the write-enable falling edge through its rising edge. Write enable stays low for at least `WE_LOW_CYC` cycles.
- R9: Data is driven only inside write cycles. `flash_dq_oe` is 0 in the cycle before output enable falls. Write enable and output enable are never low together.
- R10: A `start_i` that arrives while `busy_o` is high is ignored. The pulse count restarts from zero at each accepted start.
- R11: `busy_o` is high from the cycle after an accepted start until completion. `done_o` and `fail_o` are single-cycle pulses, never high together, raised in the first cycle with `busy_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Request strobe, taken when idle |
| addr_i | input | ADDR_W | Byte address to program |
| data_i | input | 8 | Byte value to program |
| busy_o | output | 1 | Sequence in progress |
| done_o | output | 1 | One-cycle pulse: byte verified |
| fail_o | output | 1 | One-cycle pulse: pulse budget exhausted |
| tries_o | output | CNT_W | Program pulses used by the last request |
| flash_ce_n | output | 1 | Flash chip enable, active low |
| flash_oe_n | output | 1 | Flash output enable, active low |
| flash_we_n | output | 1 | Flash write enable, active low |
| flash_addr | output | ADDR_W | Flash address bus |
| flash_dq_o | output | 8 | Data driven toward the flash |
| flash_dq_oe | output | 1 | Drive enable for `flash_dq_o` |
| flash_dq_i | input | 8 | Data returned by the flash |

## Verification
The bench contains a flash model that matches the read-back only after a chosen number of pulses. It sweeps that number from one through one past the budget. This covers the boundaries at a first-pulse pass, at a pass on exactly the last allowed pulse, and at exhaustion. A design with an off-by-one on the pulse limit would issue a 26th pulse or fail one pulse early. The model measures the pulse gap, the recovery gap and the strobe widths in cycles. A shortened timer would close the pulse or open the read too soon. A design that kept driving data into the turnaround would contend with the flash on the bus. The bench also injects a second start part-way through a run. A sequencer that took it would program the wrong address, or report a count that was not cleared.

// File: rtl/bps_pkg.sv
// Package: shared command codes and sequencer state encoding for the
// byte programming sequencer. Assumes an 8-bit flash data bus.
package bps_pkg;

    typedef logic [7:0] byte_t;

    localparam byte_t CMD_SETUP  = 8'h40;  // stage device for a program pulse
    localparam byte_t CMD_VERIFY = 8'hC0;  // end pulse, enter margin read
    localparam byte_t CMD_READ   = 8'h00;  // back to array read mode

    typedef enum logic [3:0] {
        SQ_IDLE,
        SQ_SETUP,
        SQ_DATA,
        SQ_PULSE,
        SQ_VERIFY,
        SQ_RECOV,
        SQ_RDBACK,
        SQ_EXIT
    } seq_state_t;

endpackage

// File: rtl/bps_wait_timer.sv
// Module: down-counting delay timer. A go strobe loads a length; expire
// pulses once, exactly len cycles later. Assumes len >= 1 and that go is
// only raised while the timer is idle.
module bps_wait_timer #(
    parameter int TMR_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             go,
    input  logic [TMR_W-1:0] len,
    output logic             expire
);

    logic [TMR_W-1:0] cnt_q;

    // load on go, otherwise count down to zero
    always_ff @(posedge clk) begin
        if (!rst_n)               cnt_q <= '0;
        else if (go)              cnt_q <= len;
        else if (cnt_q != '0)     cnt_q <= cnt_q - 1'b1;
    end

    assign expire = (cnt_q == TMR_W'(1));

    // R3: a new wait is never started on top of a running one
    p_no_reload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        go |-> (cnt_q == '0));

endmodule

// File: rtl/bps_bus_cycle.sv
// Module: flash bus cycle engine. Performs one write cycle (address and
// data set up, write enable low for WE_LOW_CYC cycles, one hold cycle) or
// one read cycle (one turnaround cycle with the bus released, output enable
// low for OE_LOW_CYC cycles, one closing cycle). cyc_done marks the final
// cycle of either; rdata is valid then. Assumes go only while idle.
module bps_bus_cycle
    import bps_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int WE_LOW_CYC = 8,
    parameter int OE_LOW_CYC = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go,
    input  logic              is_read,
    input  logic [ADDR_W-1:0] addr,
    input  byte_t             wdata,
    output logic              cyc_done,
    output byte_t             rdata,
    output logic              ce_n,
    output logic              oe_n,
    output logic              we_n,
    output logic [ADDR_W-1:0] bus_addr,
    output byte_t             dq_o,
    output logic              dq_oe,
    input  byte_t             dq_i
);

    localparam int STROBE_MAX = (WE_LOW_CYC > OE_LOW_CYC) ? WE_LOW_CYC : OE_LOW_CYC;
    localparam int SCNT_W     = $clog2(STROBE_MAX + 1);

    typedef enum logic [2:0] {
        BC_IDLE, BC_WSET, BC_WLOW, BC_WHOLD, BC_RTURN, BC_RLOW, BC_RDONE
    } bc_state_t;

    bc_state_t         st_q;
    logic [SCNT_W-1:0] scnt_q;
    logic [ADDR_W-1:0] addr_q;
    byte_t             wdata_q;
    byte_t             rdata_q;

    // phase sequencing and strobe-width counting
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= BC_IDLE;
            scnt_q <= '0;
        end else begin
            case (st_q)
                BC_IDLE:  if (go) st_q <= is_read ? BC_RTURN : BC_WSET;
                BC_WSET: begin
                    st_q   <= BC_WLOW;
                    scnt_q <= SCNT_W'(WE_LOW_CYC - 1);
                end
                BC_WLOW: begin
                    if (scnt_q == '0) st_q <= BC_WHOLD;
                    else              scnt_q <= scnt_q - 1'b1;
                end
                BC_WHOLD: st_q <= BC_IDLE;
                BC_RTURN: begin
                    st_q   <= BC_RLOW;
                    scnt_q <= SCNT_W'(OE_LOW_CYC - 1);
                end
                BC_RLOW: begin
                    if (scnt_q == '0) st_q <= BC_RDONE;
                    else              scnt_q <= scnt_q - 1'b1;
                end
                BC_RDONE: st_q <= BC_IDLE;
                default:  st_q <= BC_IDLE;
            endcase
        end
    end

    // latch address and write data when a cycle is launched
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            wdata_q <= '0;
        end else if (st_q == BC_IDLE && go) begin
            addr_q  <= addr;
            wdata_q <= wdata;
        end
    end

    // sample the flash data on every output-enable-low cycle
    always_ff @(posedge clk) begin
        if (!rst_n)               rdata_q <= '0;
        else if (st_q == BC_RLOW) rdata_q <= dq_i;
    end

    // strobe decode from the phase
    always_comb begin
        ce_n  = (st_q == BC_IDLE);
        we_n  = (st_q != BC_WLOW);
        oe_n  = (st_q != BC_RLOW);
        dq_oe = (st_q == BC_WSET) || (st_q == BC_WLOW) || (st_q == BC_WHOLD);
    end

    assign bus_addr = addr_q;
    assign dq_o     = wdata_q;
    assign rdata    = rdata_q;
    assign cyc_done = (st_q == BC_WHOLD) || (st_q == BC_RDONE);

    // R9: write and read strobes never overlap
    p_strobe_excl_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !(!we_n && !oe_n));
    // R9: the bus was released in the cycle before output enable fell
    p_release_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(oe_n) |-> !$past(dq_oe));
    // R9: no drive while the flash drives
    p_no_drive_read_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !oe_n |-> !dq_oe);
    // R8: address and data hold still while write enable is low
    p_addr_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> ($stable(bus_addr) && $stable(dq_o) && dq_oe));

endmodule

// File: rtl/byte_prog_seq.sv
// Module: top of the pulse-and-verify byte programming sequencer. Accepts
// one request at a time, runs set-up / data / pulse wait / verify / recovery
// wait / read-back per attempt, retries up to MAX_PULSES, then writes the
// read-mode command and reports. Assumes the programming supply is already
// up and the byte is in an erased state.
module byte_prog_seq
    import bps_pkg::*;
#(
    parameter int ADDR_W     = 17,
    parameter int MAX_PULSES = 25,
    parameter int PULSE_CYC  = 1000,
    parameter int RECOV_CYC  = 600,
    parameter int WE_LOW_CYC = 8,
    parameter int OE_LOW_CYC = 12,
    localparam int CNT_W     = $clog2(MAX_PULSES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [7:0]        data_i,
    output logic              busy_o,
    output logic              done_o,
    output logic              fail_o,
    output logic [CNT_W-1:0]  tries_o,
    output logic              flash_ce_n,
    output logic              flash_oe_n,
    output logic              flash_we_n,
    output logic [ADDR_W-1:0] flash_addr,
    output logic [7:0]        flash_dq_o,
    output logic              flash_dq_oe,
    input  logic [7:0]        flash_dq_i
);

    localparam int WAIT_MAX = (PULSE_CYC > RECOV_CYC) ? PULSE_CYC : RECOV_CYC;
    localparam int TMR_W    = $clog2(WAIT_MAX + 1);

    seq_state_t        st_q;
    logic              launched_q;
    logic [ADDR_W-1:0] tgt_addr_q;
    byte_t             tgt_data_q;
    logic [CNT_W-1:0]  pulse_cnt_q;
    logic              pass_q;
    logic              done_q, fail_q;
    logic [CNT_W-1:0]  tries_q;

    logic              bus_go, bus_rd, bus_done;
    byte_t             bus_wdata, bus_rdata;
    logic              tmr_go, tmr_expire;
    logic [TMR_W-1:0]  tmr_len;
    logic              in_bus_state, in_wait_state, step_done, byte_match;

    // classify the current step and select its operands
    always_comb begin
        in_bus_state  = (st_q == SQ_SETUP) || (st_q == SQ_DATA) || (st_q == SQ_VERIFY) ||
                        (st_q == SQ_RDBACK) || (st_q == SQ_EXIT);
        in_wait_state = (st_q == SQ_PULSE) || (st_q == SQ_RECOV);
        bus_go        = in_bus_state && !launched_q;
        tmr_go        = in_wait_state && !launched_q;
        bus_rd        = (st_q == SQ_RDBACK);
        tmr_len       = (st_q == SQ_PULSE) ? TMR_W'(PULSE_CYC) : TMR_W'(RECOV_CYC);
        step_done     = launched_q && (in_bus_state ? bus_done : tmr_expire);
        byte_match    = (bus_rdata == tgt_data_q);
        case (st_q)
            SQ_SETUP:  bus_wdata = CMD_SETUP;
            SQ_DATA:   bus_wdata = tgt_data_q;
            SQ_VERIFY: bus_wdata = CMD_VERIFY;
            default:   bus_wdata = CMD_READ;
        endcase
    end

    // step sequencing, retry counting and result capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q        <= SQ_IDLE;
            launched_q  <= 1'b0;
            tgt_addr_q  <= '0;
            tgt_data_q  <= '0;
            pulse_cnt_q <= '0;
            pass_q      <= 1'b0;
            done_q      <= 1'b0;
            fail_q      <= 1'b0;
            tries_q     <= '0;
        end else begin
            done_q <= 1'b0;
            fail_q <= 1'b0;
            if (st_q == SQ_IDLE) begin
                if (start_i) begin
                    tgt_addr_q  <= addr_i;
                    tgt_data_q  <= data_i;
                    pulse_cnt_q <= '0;
                    launched_q  <= 1'b0;
                    st_q        <= SQ_SETUP;
                end
            end else if (!launched_q) begin
                launched_q <= 1'b1;
            end else if (step_done) begin
                launched_q <= 1'b0;
                case (st_q)
                    SQ_SETUP:  st_q <= SQ_DATA;
                    SQ_DATA: begin
                        pulse_cnt_q <= pulse_cnt_q + 1'b1;
                        st_q        <= SQ_PULSE;
                    end
                    SQ_PULSE:  st_q <= SQ_VERIFY;
                    SQ_VERIFY: st_q <= SQ_RECOV;
                    SQ_RECOV:  st_q <= SQ_RDBACK;
                    SQ_RDBACK: begin
                        if (byte_match) begin
                            pass_q <= 1'b1;
                            st_q   <= SQ_EXIT;
                        end else if (pulse_cnt_q == CNT_W'(MAX_PULSES)) begin
                            pass_q <= 1'b0;
                            st_q   <= SQ_EXIT;
                        end else begin
                            st_q   <= SQ_SETUP;
                        end
                    end
                    SQ_EXIT: begin
                        done_q  <= pass_q;
                        fail_q  <= !pass_q;
                        tries_q <= pulse_cnt_q;
                        st_q    <= SQ_IDLE;
                    end
                    default:   st_q <= SQ_IDLE;
                endcase
            end
        end
    end

    bps_bus_cycle #(
        .ADDR_W     (ADDR_W),
        .WE_LOW_CYC (WE_LOW_CYC),
        .OE_LOW_CYC (OE_LOW_CYC)
    ) u_bus (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (bus_go),
        .is_read  (bus_rd),
        .addr     (tgt_addr_q),
        .wdata    (bus_wdata),
        .cyc_done (bus_done),
        .rdata    (bus_rdata),
        .ce_n     (flash_ce_n),
        .oe_n     (flash_oe_n),
        .we_n     (flash_we_n),
        .bus_addr (flash_addr),
        .dq_o     (flash_dq_o),
        .dq_oe    (flash_dq_oe),
        .dq_i     (flash_dq_i)
    );

    bps_wait_timer #(
        .TMR_W (TMR_W)
    ) u_tmr (
        .clk    (clk),
        .rst_n  (rst_n),
        .go     (tmr_go),
        .len    (tmr_len),
        .expire (tmr_expire)
    );

    assign busy_o  = (st_q != SQ_IDLE);
    assign done_o  = done_q;
    assign fail_o  = fail_q;
    assign tries_o = tries_q;

    // R11: outcome pulses are exclusive and last one cycle
    p_outcome_excl_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && fail_o));
    p_outcome_single_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |=> !(done_o || fail_o));
    // R11: outcome only reported once the sequencer is idle
    p_outcome_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o || fail_o) |-> !busy_o);
    // R10: a start while busy leaves the captured target untouched
    p_start_ignored_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> ($stable(tgt_addr_q) && $stable(tgt_data_q)));
    // R6: no pulse is launched beyond the budget
    p_pulse_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == SQ_DATA) |-> (pulse_cnt_q < CNT_W'(MAX_PULSES)));
    // R6: reported count never exceeds the budget
    p_tries_cap_r6: assert property (@(posedge clk) disable iff (!rst_n)
        tries_o <= CNT_W'(MAX_PULSES));

endmodule

// File: tb/sim_byte_prog_seq.sv
// Bench: flash model that verifies only after a chosen pulse count, swept
// from 1 to one past the budget; timing gaps measured in cycles.
module sim_byte_prog_seq;

    localparam int AW    = 17;
    localparam int MAXP  = 25;
    localparam int PCYC  = 20;
    localparam int RCYC  = 8;
    localparam int WECYC = 3;
    localparam int OECYC = 2;
    localparam int CW    = $clog2(MAXP + 1);

    localparam int K_IDLE = 0, K_SETUP = 1, K_DATA = 2, K_VERIFY = 3, K_READ = 4, K_FINAL = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic [AW-1:0] a_in = '0;
    logic [7:0]    d_in = '0;
    logic          busy, done, fail;
    logic [CW-1:0] tries;
    logic          ce_n, oe_n, we_n, dq_oe;
    logic [AW-1:0] faddr;
    logic [7:0]    dq_o, dq_i;

    int n_vec = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    // flash model state
    logic [AW-1:0] tgt_addr = '0;
    logic [7:0]    tgt_data = '0;
    int            need = 1;
    int            pulses = 0;
    int            kind = K_IDLE;
    longint        cyc = 0;
    longint        we_fall_cyc = 0, data_rise_cyc = 0, verify_rise_cyc = 0;
    logic [AW-1:0] fall_addr = '0;
    logic [7:0]    fall_data = '0;
    bit            hold_ok = 1'b1;
    logic          prev_oe_n = 1'b1, prev_we_n = 1'b1, prev_dq_oe = 1'b0;

    always #2 clk = ~clk;

    byte_prog_seq #(
        .ADDR_W(AW), .MAX_PULSES(MAXP), .PULSE_CYC(PCYC), .RECOV_CYC(RCYC),
        .WE_LOW_CYC(WECYC), .OE_LOW_CYC(OECYC)
    ) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start), .addr_i(a_in), .data_i(d_in),
        .busy_o(busy), .done_o(done), .fail_o(fail), .tries_o(tries),
        .flash_ce_n(ce_n), .flash_oe_n(oe_n), .flash_we_n(we_n), .flash_addr(faddr),
        .flash_dq_o(dq_o), .flash_dq_oe(dq_oe), .flash_dq_i(dq_i)
    );

    // read data: correct only once enough pulses have landed
    assign dq_i = (!ce_n && !oe_n) ? ((pulses >= need) ? tgt_data : (tgt_data ^ 8'hA5)) : 8'hEE;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // bus monitor and command decoder, sampled mid-cycle
    always @(negedge clk) begin
        if (rst_n) begin
            cyc++;
            if (!oe_n && !we_n) chk(1'b0, "R9 strobe overlap", 0, 1);
            if (!oe_n && dq_oe) chk(1'b0, "R9 drive during read", 1, 0);
            if (prev_oe_n && !oe_n) begin
                chk(!prev_dq_oe, "R9 release before oe", prev_dq_oe, 0);
                chk(kind == K_VERIFY, "R4 read after verify", kind, K_VERIFY);
                chk(cyc - verify_rise_cyc >= RCYC, "R4 recovery gap", cyc - verify_rise_cyc, RCYC);
                chk(faddr == tgt_addr, "R4 read address", faddr, tgt_addr);
                kind = K_READ;
            end
            if (prev_we_n && !we_n) begin
                we_fall_cyc = cyc;
                fall_addr   = faddr;
                fall_data   = dq_o;
                hold_ok     = 1'b1;
                if (kind == K_DATA)
                    chk(cyc - data_rise_cyc >= PCYC, "R3 pulse gap", cyc - data_rise_cyc, PCYC);
            end
            if (!we_n && (!dq_oe || faddr != fall_addr || dq_o != fall_data)) hold_ok = 1'b0;
            if (!prev_we_n && we_n) begin
                chk(hold_ok && (cyc - we_fall_cyc >= WECYC), "R8 write hold/width",
                    cyc - we_fall_cyc, WECYC);
                if (kind == K_SETUP) begin
                    chk(fall_addr == tgt_addr && fall_data == tgt_data, "R2 data write",
                        fall_data, tgt_data);
                    pulses++;
                    data_rise_cyc = cyc;
                    kind = K_DATA;
                end else if (fall_data == 8'h40) begin
                    chk(kind == K_IDLE || kind == K_READ, "R2 setup order", kind, K_READ);
                    kind = K_SETUP;
                end else if (fall_data == 8'hC0) begin
                    chk(kind == K_DATA, "R3 verify follows data", kind, K_DATA);
                    verify_rise_cyc = cyc;
                    kind = K_VERIFY;
                end else if (fall_data == 8'h00) begin
                    chk(kind == K_READ, "R7 read-mode after read", kind, K_READ);
                    kind = K_FINAL;
                end else begin
                    chk(1'b0, "R2 unknown command", fall_data, 8'h40);
                end
            end
            prev_oe_n  = oe_n;
            prev_we_n  = we_n;
            prev_dq_oe = dq_oe;
        end
    end

    task automatic run(input logic [AW-1:0] ad, input logic [7:0] da, input int nd, input bit inject);
        int n;
        bit exp_pass;
        int exp_tries;
        tgt_addr = ad;
        tgt_data = da;
        need     = nd;
        pulses   = 0;
        kind     = K_IDLE;
        @(negedge clk);
        start = 1'b1; a_in = ad; d_in = da;
        @(negedge clk);
        start = 1'b0;
        chk(busy, "R11 busy after start", busy, 1);
        n = 0;
        while (!(done || fail) && n < 5000) begin
            if (inject && n == 30) begin
                start = 1'b1; a_in = ~ad; d_in = ~da;   // R10: must be ignored
            end else begin
                start = 1'b0;
            end
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        exp_pass  = (nd <= MAXP);
        exp_tries = exp_pass ? nd : MAXP;
        if (exp_pass) chk(done && !fail, "R5 done on match", done, 1);
        else          chk(fail && !done, "R6 fail on budget", fail, 1);
        chk(tries == CW'(exp_tries), exp_pass ? "R5 tries" : "R6 tries", tries, exp_tries);
        chk(pulses == exp_tries, inject ? "R10 pulses after ignored start" : "R6 pulses issued",
            pulses, exp_tries);
        chk(kind == K_FINAL, "R7 last write 00h", kind, K_FINAL);
        chk(!busy, "R11 idle at outcome", busy, 0);
        @(negedge clk);
        chk(!done && !fail, "R11 single-cycle outcome", done | fail, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        chk(ce_n && oe_n && we_n && !dq_oe && !busy && !done && !fail, "R1 reset state",
            {ce_n, oe_n, we_n, dq_oe, busy, done, fail}, 7'b1110000);
        rst_n = 1'b1;
        @(negedge clk);
        chk(ce_n && oe_n && we_n && !dq_oe && !busy, "R1 idle after reset",
            {ce_n, oe_n, we_n, dq_oe, busy}, 5'b11100);
        for (int k = 1; k <= MAXP + 1; k++)
            run(AW'(k * 4099), 8'(k * 37 + 1), k, (k == 3) || (k == MAXP + 1));
        run('0, 8'h00, 1, 1'b0);
        run('1, 8'hFF, 2, 1'b0);
        run(AW'(17'h0AAAA), 8'h5A, MAXP, 1'b0);
        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            n_vec++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

endmodule